// File: doc/BRIEF.md
# External Interrupt Channel Controller

This block is the front end for eight external interrupt lines. Each line passes through a two-stage synchronizer. The synchronized value is compared with its value one cycle earlier to find edges. Every channel has four pieces of state: a trigger-polarity bit, a sticky pending latch, a mask bit and a 3-bit priority level. Among the channels that are both pending and unmasked, an arbiter picks a winner. The block presents the winner's index and level on a registered request output.

One channel, selected by a parameter, also carries a request line from an on-chip peripheral. That line is high while the peripheral's transfer-done flag or its fault flag is set, and only when the peripheral enable bit is on. A new pending event on that channel needs a fresh rising edge of the OR of the two flags. If software clears the pending bit while a flag is still set, the channel stays quiet until both flags have dropped and one of them rises again.

Software reaches the block over a small synchronous register bus. Read data is registered and appears one cycle after the read. An acknowledge input removes the request for one cycle. It does not clear the pending latch, so a pending channel is presented again until software clears it.

Top module: `xirq_top`

## Requirements
- R1: After synchronous reset, every register reads 0 and `irq_req` is low. Trigger bit 0 means falling edge.
- R2: With trigger bit i set to 1 (register address 0), a 0-to-1 transition on channel i's input sets pending bit i. Pending is readable at address 1.
- R3: With trigger bit i at 0, a 1-to-0 transition on channel i's input sets pending bit i.
- R4: A transition of the non-selected polarity, or a steady level, leaves pending bit i unchanged.
- R5: A pending channel whose mask bit (address 2) is 0 produces no request. When at least one pending channel is unmasked, `irq_req` is high.
- R6: Priority is 3 bits at address 8+i, in bits [2:0]. `irq_id` and `irq_lvl` name the pending, unmasked channel with the highest level. On equal levels the lowest index wins.
- R7: Writing address 1 clears each pending bit whose data bit is 1. Data bits at 0 leave their pending bits as they are.
- R8: When an edge and a clear of the same pending bit fall in one cycle, the bit stays set.
- R9: `irq_ack` high in a cycle forces `irq_req` low in the next cycle. It leaves pending unchanged, and the request returns the cycle after that if the channel is still pending.
- R10: On channel PERIPH_CH (default 5), the input is the external pin ORed with (enable bit 0 of address 3) AND (`periph_done` OR `periph_fault`). A rising edge of that line sets the channel's pending bit when its trigger bit is 1. With the enable bit at 0, the flags have no effect.
- R11: While one peripheral flag is set, setting the other flag creates no new pending event. After a clear while a flag is still set, no pending event occurs until both flags are 0 and one is set again.
- R12: A read returns, on `bus_rdata` one cycle later, the register contents. Unused bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_in | input | 8 | Asynchronous external interrupt lines |
| periph_done | input | 1 | Peripheral transfer-done flag |
| periph_fault | input | 1 | Peripheral fault flag |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_req | output | 1 | Interrupt request |
| irq_id | output | 3 | Winning channel index |
| irq_lvl | output | 3 | Winning channel priority level |
| irq_ack | input | 1 | Request acknowledge |

## Verification
The bench times an external edge so that its pending update lands in the same cycle as a software clear of that bit. A design that lets the clear win would lose the event and read back 0. It drives the second peripheral flag while the first is still set, and clears pending under a held flag. A design that detected flag levels instead of line edges would raise requests that should not exist. Random priority and mask patterns with forced level ties check the lowest-index rule: an arbiter that scanned downward or used `>=` would name the wrong channel. The acknowledge test reads pending back after the one-cycle drop, which catches a design that clears the latch on acknowledge.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_TRIG = 4'h0,
    REG_PEND = 4'h1,
    REG_MASK = 4'h2,
    REG_CTRL = 4'h3
  } reg_addr_e;

  localparam logic [ADDR_W-1:0] REG_PRIO_BASE = 4'h8;
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int N      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw,
  output logic [N-1:0] cur,
  output logic [N-1:0] prev
);
  logic [N-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= raw;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= stage_q[STAGES-1];
  end

  assign cur = stage_q[STAGES-1];
endmodule

// File: rtl/xirq_pend.sv
module xirq_pend #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] cur,
  input  logic [N-1:0] prev,
  input  logic [N-1:0] trig,
  input  logic [N-1:0] clr,
  output logic [N-1:0] edge_vec,
  output logic [N-1:0] pend
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_ch
      logic rise, fall;
      assign rise        = cur[i] & ~prev[i];
      assign fall        = ~cur[i] & prev[i];
      assign edge_vec[i] = trig[i] ? rise : fall;

      always_ff @(posedge clk) begin
        if (rst)              pend[i] <= 1'b0;
        else if (edge_vec[i]) pend[i] <= 1'b1;
        else if (clr[i])      pend[i] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
  import xirq_pkg::*;
#(
  parameter int N      = 8,
  parameter int PRIO_W = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bus_sel,
  input  logic                         bus_wr,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [DATA_W-1:0]            bus_wdata,
  output logic [DATA_W-1:0]            bus_rdata,
  input  logic [N-1:0]                 pend,
  output logic [N-1:0]                 trig,
  output logic [N-1:0]                 mask,
  output logic                         periph_en,
  output logic [N-1:0][PRIO_W-1:0]     prio,
  output logic [N-1:0]                 clr
);
  localparam int IDX_W = ADDR_W - 1;

  logic wr_en, rd_en;
  logic [DATA_W-1:0] rd_mux;

  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;

  assign clr = (wr_en && bus_addr == REG_PEND) ? bus_wdata[N-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      trig      <= '0;
      mask      <= '0;
      periph_en <= 1'b0;
    end else if (wr_en) begin
      case (bus_addr)
        REG_TRIG: trig      <= bus_wdata[N-1:0];
        REG_MASK: mask      <= bus_wdata[N-1:0];
        REG_CTRL: periph_en <= bus_wdata[0];
        default: ;
      endcase
    end
  end

  generate
    for (genvar i = 0; i < N; i++) begin : g_prio
      always_ff @(posedge clk) begin
        if (rst)
          prio[i] <= '0;
        else if (wr_en && bus_addr == (REG_PRIO_BASE | ADDR_W'(i)))
          prio[i] <= bus_wdata[PRIO_W-1:0];
      end
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    if (bus_addr[ADDR_W-1]) begin
      for (int i = 0; i < N; i++)
        if (bus_addr[IDX_W-1:0] == IDX_W'(i))
          rd_mux[PRIO_W-1:0] = prio[i];
    end else begin
      case (bus_addr)
        REG_TRIG: rd_mux[N-1:0] = trig;
        REG_PEND: rd_mux[N-1:0] = pend;
        REG_MASK: rd_mux[N-1:0] = mask;
        REG_CTRL: rd_mux[0]     = periph_en;
        default:  rd_mux        = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/xirq_arb.sv
module xirq_arb #(
  parameter int N      = 8,
  parameter int PRIO_W = 3,
  localparam int ID_W  = $clog2(N)
) (
  input  logic [N-1:0]             req,
  input  logic [N-1:0][PRIO_W-1:0] prio,
  output logic                     any,
  output logic [ID_W-1:0]          win_id,
  output logic [PRIO_W-1:0]        win_lvl
);
  always_comb begin
    any     = 1'b0;
    win_id  = '0;
    win_lvl = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!any || prio[i] > win_lvl)) begin
        any     = 1'b1;
        win_id  = ID_W'(i);
        win_lvl = prio[i];
      end
    end
  end
endmodule

// File: rtl/xirq_top.sv
module xirq_top
  import xirq_pkg::*;
#(
  parameter int N         = 8,
  parameter int PRIO_W    = 3,
  parameter int SYNC_LEN  = 2,
  parameter int PERIPH_CH = 5,
  localparam int ID_W     = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        ext_in,
  input  logic                periph_done,
  input  logic                periph_fault,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                irq_req,
  output logic [ID_W-1:0]     irq_id,
  output logic [PRIO_W-1:0]   irq_lvl,
  input  logic                irq_ack
);
  logic [N-1:0]             raw, cur, prev, edge_vec, pend_q, clr_vec;
  logic [N-1:0]             trig_q, mask_q;
  logic [N-1:0][PRIO_W-1:0] prio_q;
  logic                     periph_en, periph_line;
  logic                     win_any;
  logic [ID_W-1:0]          win_id;
  logic [PRIO_W-1:0]        win_lvl;

  assign periph_line = periph_en & (periph_done | periph_fault);

  always_comb begin
    raw            = ext_in;
    raw[PERIPH_CH] = ext_in[PERIPH_CH] | periph_line;
  end

  xirq_sync #(.N(N), .STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst(rst), .raw(raw), .cur(cur), .prev(prev)
  );

  xirq_pend #(.N(N)) u_pend (
    .clk(clk), .rst(rst), .cur(cur), .prev(prev), .trig(trig_q),
    .clr(clr_vec), .edge_vec(edge_vec), .pend(pend_q)
  );

  xirq_regs #(.N(N), .PRIO_W(PRIO_W)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pend(pend_q), .trig(trig_q), .mask(mask_q), .periph_en(periph_en),
    .prio(prio_q), .clr(clr_vec)
  );

  xirq_arb #(.N(N), .PRIO_W(PRIO_W)) u_arb (
    .req(pend_q & mask_q), .prio(prio_q), .any(win_any),
    .win_id(win_id), .win_lvl(win_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_id  <= '0;
      irq_lvl <= '0;
    end else begin
      irq_req <= win_any & ~irq_ack;
      irq_id  <= win_id;
      irq_lvl <= win_lvl;
    end
  end
endmodule

// File: rtl/xirq_chk.sv
module xirq_chk #(
  parameter int N      = 8,
  parameter int ID_W   = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            irq_req,
  input logic [ID_W-1:0] irq_id,
  input logic            irq_ack,
  input logic [N-1:0]    pend,
  input logic [N-1:0]    mask,
  input logic [N-1:0]    edge_vec,
  input logic [N-1:0]    clr_vec
);
  // R2/R3: a detected edge always leaves its pending bit set
  assert_edge_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (edge_vec != '0) |=> ((pend & $past(edge_vec)) == $past(edge_vec)));

  // R4: no pending bit rises without a detected edge
  assert_no_spurious_R4: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((pend & ~$past(pend) & ~$past(edge_vec)) == '0));

  // R5: nothing pending and unmasked means no request next cycle
  assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    ((pend & mask) == '0) |=> !irq_req);

  // R6: the presented channel was pending and unmasked
  assert_id_valid_R6: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> ((($past(pend & mask)) >> irq_id) & 1) != '0);

  // R7: a clear without a coincident edge empties the bit
  assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
    ((clr_vec & ~edge_vec) != '0) |=> ((pend & $past(clr_vec & ~edge_vec)) == '0));

  // R8: edge beats clear
  assert_edge_wins_R8: assert property (@(posedge clk) disable iff (rst)
    ((clr_vec & edge_vec) != '0) |=>
      ((pend & $past(clr_vec & edge_vec)) == $past(clr_vec & edge_vec)));

  // R9: acknowledge drops the request for one cycle
  assert_ack_drop_R9: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !irq_req);
endmodule

bind xirq_top xirq_chk #(.N(N), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst(rst), .irq_req(irq_req), .irq_id(irq_id), .irq_ack(irq_ack),
  .pend(pend_q), .mask(mask_q), .edge_vec(edge_vec), .clr_vec(clr_vec)
);

// File: tb/tb_xirq_top.sv
`timescale 1ns/1ps
module tb_xirq_top;
  logic       clk = 0;
  logic       rst = 1;
  logic [7:0] ext_in = '0;
  logic       periph_done = 0, periph_fault = 0;
  logic       bus_sel = 0, bus_wr = 0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_req;
  logic [2:0] irq_id, irq_lvl;
  logic       irq_ack = 0;

  int checks = 0, errors = 0;
  bit finished = 0;
  int prio_m [8];

  always #2.5 clk = ~clk;

  xirq_top dut (
    .clk(clk), .rst(rst), .ext_in(ext_in), .periph_done(periph_done),
    .periph_fault(periph_fault), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .irq_id(irq_id), .irq_lvl(irq_lvl), .irq_ack(irq_ack)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  function automatic int exp_id(input logic [7:0] req);
    int best = -1;
    for (int i = 0; i < 8; i++)
      if (req[i] && (best < 0 || prio_m[i] > prio_m[best])) best = i;
    return best < 0 ? 0 : best;
  endfunction

  task automatic set_prio(input int ch, input int p);
    prio_m[ch] = p;
    wr(4'h8 | 4'(ch), 8'(p));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 8; i++) prio_m[i] = 0;
    idle(3); rst = 0; idle(2);

    // R1: reset state
    chk("R1 irq_req", irq_req, 0);
    rd(4'h0, d); chk("R1 trig", d, 0);
    rd(4'h1, d); chk("R1 pend", d, 0);
    rd(4'h2, d); chk("R1 mask", d, 0);
    rd(4'h8, d); chk("R1 prio0", d, 0);

    // R12: read-back, unused bits zero
    wr(4'h2, 8'hA5); rd(4'h2, d); chk("R12 mask readback", d, 8'hA5);
    wr(4'hB, 8'hFF); rd(4'hB, d); chk("R12 prio3 width", d, 8'h07);
    wr(4'h3, 8'hFE); rd(4'h3, d); chk("R12 ctrl bits", d, 0);
    wr(4'h2, 8'h00); wr(4'hB, 8'h00);

    // R3/R4: falling-edge mode on channel 1
    ext_in[1] = 1; idle(5);
    rd(4'h1, d); chk("R4 rise ignored in falling mode", d, 0);
    ext_in[1] = 0; idle(5);
    rd(4'h1, d); chk("R3 falling edge sets", d, 8'h02);
    // R5: masked -> no request
    chk("R5 masked no req", irq_req, 0);
    wr(4'h2, 8'h02); idle(2);
    chk("R5 unmasked req", irq_req, 1);
    chk("R5 id", irq_id, 1);
    // R7: writing 0 bits leaves pending, 1 bit clears
    wr(4'h1, 8'hFD); rd(4'h1, d); chk("R7 zero bit keeps", d, 8'h02);
    wr(4'h1, 8'h02); rd(4'h1, d); chk("R7 one bit clears", d, 0);
    idle(1); chk("R7 req gone", irq_req, 0);

    // R2/R4: rising mode on channel 2
    wr(4'h0, 8'hFF);
    ext_in[2] = 1; idle(5);
    rd(4'h1, d); chk("R2 rising edge sets", d, 8'h04);
    wr(4'h1, 8'h04);
    ext_in[2] = 0; idle(5);
    rd(4'h1, d); chk("R4 fall ignored in rising mode", d, 0);

    // R8: edge and clear same cycle
    @(negedge clk); ext_in[2] = 1;
    @(negedge clk);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = 4'h1; bus_wdata = 8'h04;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
    rd(4'h1, d); chk("R8 edge wins over clear", d, 8'h04);
    wr(4'h1, 8'h04); ext_in[2] = 0; idle(4);

    // R6: directed priority
    set_prio(3, 5); set_prio(6, 5); set_prio(1, 2);
    wr(4'h2, 8'hFF);
    ext_in = 8'b0100_1010; idle(6);
    chk("R6 tie lowest index id", irq_id, 3);
    chk("R6 level", irq_lvl, 5);

    // R9: ack does not clear
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
    chk("R9 req drops after ack", irq_req, 0);
    @(negedge clk);
    chk("R9 req returns", irq_req, 1);
    rd(4'h1, d); chk("R9 pending kept", d, 8'h4A);
    wr(4'h1, 8'hFF); ext_in = '0; idle(4);
    rd(4'h1, d); chk("R7 clear all", d, 0);

    // R6/R5 random
    for (int it = 0; it < 40; it++) begin
      logic [7:0] pat, msk;
      pat = 8'($urandom); msk = 8'($urandom);
      for (int c = 0; c < 8; c++) set_prio(c, int'($urandom % 4)); // small range forces ties
      wr(4'h2, msk);
      ext_in = pat; idle(6);
      rd(4'h1, d); chk("R2 random pend", d, pat);
      chk("R5 random req", irq_req, ((pat & msk) != 0) ? 1 : 0);
      if ((pat & msk) != 0) begin
        chk("R6 random id", irq_id, exp_id(pat & msk));
        chk("R6 random lvl", irq_lvl, prio_m[exp_id(pat & msk)]);
      end
      wr(4'h1, 8'hFF); ext_in = '0; idle(4);
    end
    rd(4'h1, d); chk("R7 random cleanup", d, 0);

    // R10: peripheral channel 5
    wr(4'h2, 8'h20);
    periph_done = 1; idle(5);
    rd(4'h1, d); chk("R10 disabled flags ignored", d, 0);
    periph_done = 0; idle(4);
    wr(4'h3, 8'h01);
    periph_done = 1; idle(5);
    rd(4'h1, d); chk("R10 done sets ch5", d, 8'h20);
    chk("R10 req id", irq_id, 5);
    // R11: clear with flag still set
    wr(4'h1, 8'h20); idle(4);
    rd(4'h1, d); chk("R11 no repend while flag held", d, 0);
    periph_fault = 1; idle(5);
    rd(4'h1, d); chk("R11 second flag no edge", d, 0);
    chk("R11 no req", irq_req, 0);
    periph_done = 0; idle(5);
    rd(4'h1, d); chk("R11 one flag drop no edge", d, 0);
    periph_fault = 0; idle(5);
    periph_fault = 1; idle(5);
    rd(4'h1, d); chk("R11 fresh flag sets", d, 8'h20);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule